// File: doc/BRIEF.md
# UART Receive Queue with Idle Timeout

This block is the host-facing half of a UART receiver. A deserializer upstream hands over finished characters, each with an 8-bit data byte and three error flags (parity, framing, line break). The block stores each character together with its flags. In queue mode it holds up to 16 characters; with queue mode off it holds exactly one. The host sees the oldest character on a read-only data port, with that character's flags alongside it as line-status bits. A read strobe retires the head, and the next character and its flags become visible in the following cycle.

Two sources feed one receive interrupt. The level source asserts once the fill count reaches a programmable threshold in queue mode, or as soon as any character is held in single mode. The idle source fires when characters sit unread and no new one has arrived for a span derived from the programmed word length. This guarantees delivery of data that never reaches the threshold. A character that arrives with no room is discarded, and a sticky overrun bit records the loss.

Top module: `rxq_top`

## Requirements
- R1: In queue mode (`fifo_en`=1) up to 16 characters are stored and presented on `hold_data` in arrival order. `data_ready` is 1 exactly while at least one character is held.
- R2: `line_err` shows the 3 flags stored with the head character. After a `hold_rd` pulse, the next character's flags appear in the following cycle.
- R3: A character strobed while the store is full, with no simultaneous read, is discarded. It sets `overrun`, which stays 1 until a `status_rd` pulse. If the set and the clear fall in the same cycle, the set wins.
- R4: With `fifo_en`=0 the store holds one character. A second character that arrives before the first is read is discarded and sets `overrun`.
- R5: In queue mode the level source asserts while the fill count is at least the threshold selected by `trig_sel`: 00=1, 01=4, 10=8, 11=14.
- R6: With `fifo_en`=0 the level source asserts as soon as one character is held.
- R7: The idle source (`irq_is_timeout`) sets after L consecutive `bit_tick` pulses with data held and no character strobe or read. L = 4*(5+`word_len`)+12, so `word_len` 00 gives 32 and 11 gives 44. A character strobe or a read restarts the count, and no counting happens while the store is empty.
- R8: A `hold_rd` that retires a character clears the idle source in the next cycle.
- R9: `irq_rx` equals `rx_irq_en` AND (level source OR idle source).
- R10: A `hold_rd` while empty leaves `hold_data` at the last character read. It does not move the read position, so the next arriving character is the one presented.
- R11: When a character strobe and a read fall in the same cycle on a full store, the new character is accepted and `overrun` is not set.
- R12: After reset the store is empty: `data_ready`=0, `overrun`=0, `irq_rx`=0 and `irq_is_timeout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| word_len | input | 2 | Data bits minus 5; sets the idle span |
| trig_sel | input | 2 | Level threshold select (1, 4, 8, 14) |
| rx_irq_en | input | 1 | Enable for the receive interrupt |
| chr_valid | input | 1 | One-cycle strobe: a character is delivered |
| chr_data | input | 8 | Data byte of the delivered character |
| chr_err | input | 3 | Error flags of the delivered character |
| bit_tick | input | 1 | One pulse per serial bit time |
| hold_rd | input | 1 | Host read of the holding register |
| status_rd | input | 1 | Host read of the line status |
| hold_data | output | 8 | Head data byte, or last read byte when empty |
| data_ready | output | 1 | At least one character held |
| line_err | output | 3 | Error flags of the head character |
| overrun | output | 1 | Sticky character-loss flag |
| irq_rx | output | 1 | Gated receive interrupt |
| irq_is_timeout | output | 1 | Idle source active |

## Verification
A character strobe and a host read can fall in the same cycle. That matters most on a full queue, where the store must take the new character, because the read frees a slot, and must not flag an overrun. The bench fills all 16 entries, checks the head, then raises `chr_valid` and `hold_rd` together. The scoreboard expects the overrun bit to stay clear, and it expects all 16 survivors, the new one last, to drain in order with matching flags. The idle counter sees the same collision: an arrival restarts it without clearing a pending idle event, while a read does both. The bench checks this by ticking across the exact threshold before and after each kind of event.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;

  typedef struct packed {
    logic [TAG_W-1:0]  tags;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             wr_req,
  input  rxq_entry_t       wr_entry,
  input  logic             rd_req,
  output rxq_entry_t       head_entry,
  output logic [DATA_W-1:0] last_data,
  output logic [CNT_W-1:0] fill,
  output logic             pop,
  output logic             drop
);
  rxq_entry_t       mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic [DATA_W-1:0] last_q, last_d;
  logic [CNT_W-1:0] cap;
  logic             full, push;

  always_comb begin
    cap  = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    full = (fill_q >= cap);
    pop  = rd_req && (fill_q != '0);
    push = wr_req && (!full || pop);
    drop = wr_req && !push;

    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    fill_d   = fill_q;
    last_d   = last_q;
    if (push) wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      last_d   = mem[rd_ptr_q].data;
    end
    case ({push, pop})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      last_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
      last_q   <= last_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (wr_ptr_q == AW'(gi));
    always_ff @(posedge clk) begin
      if (slot_we) mem[gi] <= wr_entry;
    end
  end

  assign head_entry = mem[rd_ptr_q];
  assign last_data  = last_q;
  assign fill       = fill_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));
  assert_empty_read_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && fill_q == '0 && !wr_req) |=> ($stable(rd_ptr_q) && fill_q == '0));
  assert_collision_accepts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && rd_req && fill_q != '0) |=> $stable(fill_q));
endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
  parameter int CNT_W = 5
) (
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] fill,
  output logic             level_hit
);
  logic [CNT_W-1:0] level;

  always_comb begin
    case (trig_sel)
      2'b00:   level = CNT_W'(1);
      2'b01:   level = CNT_W'(4);
      2'b10:   level = CNT_W'(8);
      default: level = CNT_W'(14);
    endcase
    level_hit = fifo_en ? (fill >= level) : (fill != '0);
  end
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TMO_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] word_len,
  input  logic       bit_tick,
  input  logic       nonempty,
  input  logic       arrive,
  input  logic       retire,
  output logic       tmo
);
  logic [TMO_W-1:0] cnt_q, cnt_d, limit;
  logic             tmo_q, tmo_d, hit;

  always_comb begin
    limit = TMO_W'(32) + TMO_W'({word_len, 2'b00});
    hit   = nonempty && bit_tick && !arrive && !retire && !tmo_q &&
            (cnt_q == limit - 1'b1);
    cnt_d = cnt_q;
    if (arrive || retire)                        cnt_d = '0;
    else if (nonempty && bit_tick && cnt_q != limit) cnt_d = cnt_q + 1'b1;
    tmo_d = tmo_q;
    if (retire)   tmo_d = 1'b0;
    else if (hit) tmo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  assign tmo = tmo_q;

  assert_idle_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(nonempty && bit_tick));
  assert_idle_clears_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !tmo_q);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TMO_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fifo_en,
  input  logic [1:0]  word_len,
  input  logic [1:0]  trig_sel,
  input  logic        rx_irq_en,
  input  logic        chr_valid,
  input  logic [7:0]  chr_data,
  input  logic [2:0]  chr_err,
  input  logic        bit_tick,
  input  logic        hold_rd,
  input  logic        status_rd,
  output logic [7:0]  hold_data,
  output logic        data_ready,
  output logic [2:0]  line_err,
  output logic        overrun,
  output logic        irq_rx,
  output logic        irq_is_timeout
);
  rxq_entry_t        wr_entry, head_entry;
  logic [DATA_W-1:0] last_data;
  logic [CNT_W-1:0]  fill;
  logic              pop, drop, level_hit, tmo, ovr_q, ovr_d, nonempty;

  always_comb begin
    wr_entry.data = chr_data;
    wr_entry.tags = chr_err;
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .wr_req(chr_valid), .wr_entry(wr_entry), .rd_req(hold_rd),
    .head_entry(head_entry), .last_data(last_data), .fill(fill),
    .pop(pop), .drop(drop)
  );

  rxq_trigger #(.CNT_W(CNT_W)) u_trig (
    .fifo_en(fifo_en), .trig_sel(trig_sel), .fill(fill), .level_hit(level_hit)
  );

  assign nonempty = (fill != '0);

  rxq_timeout #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .word_len(word_len), .bit_tick(bit_tick),
    .nonempty(nonempty), .arrive(chr_valid), .retire(pop), .tmo(tmo)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (drop)           ovr_d = 1'b1;
    else if (status_rd) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  always_comb begin
    data_ready     = nonempty;
    hold_data      = nonempty ? head_entry.data : last_data;
    line_err       = nonempty ? head_entry.tags : '0;
    overrun        = ovr_q;
    irq_is_timeout = tmo;
    irq_rx         = rx_irq_en && (level_hit || tmo);
  end

  assert_drop_sets_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);
  assert_single_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && chr_valid && data_ready && !hold_rd) |=> overrun);
  assert_no_irq_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_irq_en) |-> !irq_rx);
endmodule

// File: tb/test_rxq_top.sv
module test_rxq_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 1'b1, rx_irq_en = 1'b0, chr_valid = 1'b0, bit_tick = 1'b0;
  logic hold_rd = 1'b0, status_rd = 1'b0;
  logic [1:0] word_len = 2'b00, trig_sel = 2'b11;
  logic [7:0] chr_data = '0;
  logic [2:0] chr_err = '0;
  logic [7:0] hold_data;
  logic data_ready, overrun, irq_rx, irq_is_timeout;
  logic [2:0] line_err;

  int total = 0, bad = 0;
  logic [10:0] sb[$];
  int cap = 16;
  logic exp_ovr = 1'b0;
  logic [7:0] exp_last = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  rxq_top i_rxq_top (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .word_len(word_len),
    .trig_sel(trig_sel), .rx_irq_en(rx_irq_en), .chr_valid(chr_valid),
    .chr_data(chr_data), .chr_err(chr_err), .bit_tick(bit_tick),
    .hold_rd(hold_rd), .status_rd(status_rd), .hold_data(hold_data),
    .data_ready(data_ready), .line_err(line_err), .overrun(overrun),
    .irq_rx(irq_rx), .irq_is_timeout(irq_is_timeout)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one character, expected result pushed to scoreboard
  task automatic send(logic [7:0] d, logic [2:0] e);
    chr_valid = 1'b1; chr_data = d; chr_err = e;
    if (sb.size() < cap) sb.push_back({e, d}); else exp_ovr = 1'b1;
    @(negedge clk);
    chr_valid = 1'b0;
    check("R3 overrun", overrun, exp_ovr);
  endtask

  // monitor: compare head with scoreboard, then retire it
  task automatic take(string req);
    logic [10:0] e;
    e = sb.pop_front();
    check({req, " ready"}, data_ready, 1);
    check({req, " data"}, hold_data, e[7:0]);
    check({"R2 tags ", req}, line_err, e[10:8]);
    exp_last = e[7:0];
    hold_rd = 1'b1; @(negedge clk); hold_rd = 1'b0;
  endtask

  task automatic ticks(int n);
    bit_tick = 1'b1; repeat (n) @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic status_read();
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
    exp_ovr = 1'b0;
    check("R3 overrun clear", overrun, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 ready", data_ready, 0);
    check("R12 overrun", overrun, 0);
    check("R12 irq", irq_rx, 0);
    check("R12 timeout", irq_is_timeout, 0);

    // R1/R2/R3: fill, overflow, drain in order
    for (int i = 0; i < 16; i++) send(8'(8'h30 + i), 3'(i));
    check("R1 ready", data_ready, 1);
    send(8'hEE, 3'b111);
    check("R3 overrun set", overrun, 1);
    status_read();
    while (sb.size() > 0) take("R1");
    check("R1 empty", data_ready, 0);

    // R10: empty read keeps last value, pointer unmoved
    hold_rd = 1'b1; @(negedge clk); hold_rd = 1'b0;
    check("R10 last", hold_data, exp_last);
    check("R10 ready", data_ready, 0);
    send(8'h5A, 3'b010);
    take("R10 next");

    // R11: collision on full queue
    for (int i = 0; i < 16; i++) send(8'(8'h80 + i), 3'(7 - (i % 8)));
    check("R11 head", hold_data, 8'h80);
    chr_valid = 1'b1; chr_data = 8'hC3; chr_err = 3'b101; hold_rd = 1'b1;
    void'(sb.pop_front());
    sb.push_back({3'b101, 8'hC3});
    @(negedge clk);
    chr_valid = 1'b0; hold_rd = 1'b0;
    check("R11 no overrun", overrun, 0);
    check("R11 head next", hold_data, 8'h81);
    while (sb.size() > 0) take("R11");

    // R5 trigger levels, R9 gating
    rx_irq_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      int lvl;
      lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      trig_sel = 2'(s);
      for (int i = 0; i < lvl - 1; i++) send(8'(i), 3'b000);
      check("R5 below", irq_rx, 0);
      send(8'hAA, 3'b001);
      check("R5 at", irq_rx, 1);
      while (sb.size() > 0) take("R5");
    end
    trig_sel = 2'b00;
    rx_irq_en = 1'b0;
    send(8'h11, 3'b000);
    check("R9 masked", irq_rx, 0);
    rx_irq_en = 1'b1;
    @(negedge clk);
    check("R9 enabled", irq_rx, 1);
    take("R9");

    // R4/R6 single mode
    fifo_en = 1'b0; cap = 1; trig_sel = 2'b11;
    check("R6 idle", irq_rx, 0);
    send(8'h41, 3'b100);
    check("R6 irq", irq_rx, 1);
    send(8'h42, 3'b000);
    check("R4 overrun", overrun, 1);
    status_read();
    take("R4");
    check("R4 empty", data_ready, 0);
    fifo_en = 1'b1; cap = 16;

    // R7/R8 idle timeout, word_len 00 -> 32
    trig_sel = 2'b11; word_len = 2'b00;
    ticks(50);
    check("R7 empty no count", irq_is_timeout, 0);
    send(8'h61, 3'b000);
    ticks(31);
    check("R7 before 32", irq_is_timeout, 0);
    ticks(1);
    check("R7 at 32", irq_is_timeout, 1);
    check("R9 idle irq", irq_rx, 1);
    send(8'h62, 3'b000);
    check("R7 arrival keeps event", irq_is_timeout, 1);
    take("R8");
    check("R8 cleared", irq_is_timeout, 0);
    ticks(20);
    send(8'h63, 3'b000);
    ticks(20);
    check("R7 restart by arrival", irq_is_timeout, 0);
    ticks(12);
    check("R7 after restart", irq_is_timeout, 1);
    take("R8");
    take("R8");
    check("R8 empty", irq_is_timeout, 0);

    // R7 word_len 11 -> 44
    word_len = 2'b11;
    send(8'h70, 3'b000);
    ticks(43);
    check("R7 before 44", irq_is_timeout, 0);
    ticks(1);
    check("R7 at 44", irq_is_timeout, 1);
    take("R8");
    check("R8 wl11 cleared", irq_is_timeout, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule